// File: doc/BRIEF.md
# Hash Accelerator Control and Status Register Front-End

This block is the register-facing side of a hash accelerator. A host writes the source buffer address, the digest buffer address, the key buffer address and the byte length of a job through a plain 32-bit register port. A write to the command register then launches one job. The block passes the held values, the decoded algorithm and two mode flags to an abstract hash datapath, together with a one-cycle start strobe. It waits for the datapath's completion pulse and reports progress through a status word that the host polls.

The status word carries a busy bit, a completion flag that the host clears by writing 1, and an overflow flag. The overflow flag records a command that arrived while a job was still running. Such a command is dropped and the running job continues. While a job runs, all configuration writes are refused, so the job sees stable inputs from start to finish. A command whose algorithm field matches no supported code is stored but starts nothing.

Control is a three-state machine:
- **IDLE**: no job is running.
- **LAUNCH**: lasts one cycle and raises the start strobe.
- **WAIT**: the block holds until the datapath reports completion.

The transitions are:
- **accept**: IDLE to LAUNCH, on a command write with a valid algorithm.
- **issue**: LAUNCH to WAIT.
- **finish**: LAUNCH or WAIT to IDLE, on the completion pulse.

Top module: `hash_csr_frontend`

## Requirements
- R1: After reset, every register reads zero, the status word reads zero and `job_start` is low.
- R2: The source address is at offset 0x20, the digest address at 0x24, the key address at 0x28, the length at 0x2C and the command at 0x30. Each reads back the value last written while idle. The length keeps only its low LEN_W bits and reads zero above them.
- R3: A command write with a valid algorithm while idle raises `job_start` for exactly one cycle, in the cycle after the write. Status bit 0 (busy) reads 1 from that same cycle.
- R4: The algorithm is taken from command bits {10,6,5,4}. The code 0010 gives `job_algo`=1, 0101 gives 2, 1110 gives 3 and 0110 gives 4. `job_accum` follows command bit 8 and `job_big_endian` follows command bit 3.
- R5: A command write whose algorithm code is none of the four in R4 does not raise `job_start` and leaves busy at 0.
- R6: A `job_done` pulse while busy clears busy and sets status bit 9 at the same clock edge. A `job_done` pulse while idle has no effect.
- R7: Writing status with bit 9 set clears bit 9. Writing 0 there leaves it unchanged. If completion and the clearing write arrive at the same edge, bit 9 ends set.
- R8: A command write while busy is dropped. No new start occurs, the stored command and `job_algo` are unchanged, and status bit 23 sets. Writing status with bit 23 set clears that bit.
- R9: Writes to offsets 0x20 to 0x30 while busy leave the stored values unchanged.
- R10: Reads of offsets other than 0x1C and 0x20 to 0x30 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| job_start | output | 1 | One-cycle job launch strobe |
| job_src_addr | output | 32 | Source data address |
| job_digest_addr | output | 32 | Digest buffer address |
| job_key_addr | output | 32 | Key buffer address |
| job_len | output | LEN_W | Data length in bytes |
| job_algo | output | 3 | Decoded algorithm: 0 none, 1 to 4 as in R4 |
| job_accum | output | 1 | Accumulate mode: the digest buffer is both the chaining input and the output |
| job_big_endian | output | 1 | Big-endian word ordering |
| job_done | input | 1 | Completion pulse from the datapath |

## Verification
The bench builds the block with ADDR_W=8 and LEN_W=24. The narrowed length register lets the bench see that upper length bits are dropped on write and read back as zero. The 8-bit offset space lets the bench reach mapped and unmapped offsets at both ends of the map. The bench covers every algorithm code and some invalid ones. It also covers a command and configuration writes issued during a running job, and the collision of completion with a clearing write on the same edge.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    typedef enum logic [2:0] {
        ALG_NONE   = 3'd0,
        ALG_SHA1   = 3'd1,
        ALG_SHA256 = 3'd2,
        ALG_SHA384 = 3'd3,
        ALG_SHA512 = 3'd4
    } hcf_algo_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } hcf_state_e;

    // Register byte offsets
    localparam int unsigned OFS_STATUS = 32'h1C;
    localparam int unsigned OFS_SRC    = 32'h20;
    localparam int unsigned OFS_DIGEST = 32'h24;
    localparam int unsigned OFS_KEY    = 32'h28;
    localparam int unsigned OFS_LEN    = 32'h2C;
    localparam int unsigned OFS_CMD    = 32'h30;

    // Field positions
    localparam int unsigned STS_BUSY_BIT = 0;
    localparam int unsigned STS_DONE_BIT = 9;
    localparam int unsigned STS_OVF_BIT  = 23;
    localparam int unsigned CMD_BE_BIT   = 3;
    localparam int unsigned CMD_ACC_BIT  = 8;

endpackage

// File: rtl/hcf_algo_decode.sv
module hcf_algo_decode
    import hcf_pkg::*;
(
    input  logic [3:0] alg_bits,   // command bits {10,6,5,4}
    output hcf_algo_e  algo
);
    always_comb begin
        unique case (alg_bits)
            4'b0010: algo = ALG_SHA1;
            4'b0101: algo = ALG_SHA256;
            4'b1110: algo = ALG_SHA384;
            4'b0110: algo = ALG_SHA512;
            default: algo = ALG_NONE;
        endcase
    end
endmodule

// File: rtl/hcf_job_fsm.sv
module hcf_job_fsm
    import hcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hit,
    input  logic algo_ok,
    input  logic job_done,
    output logic busy,
    output logic job_start,
    output logic done_set,
    output logic cmd_reject
);
    hcf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_hit && algo_ok) state_d = ST_LAUNCH;  // accept
            ST_LAUNCH: state_d = job_done ? ST_IDLE : ST_WAIT;       // finish / issue
            ST_WAIT:   if (job_done) state_d = ST_IDLE;              // finish
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        job_start  = (state_q == ST_LAUNCH);
        done_set   = busy && job_done;
        cmd_reject = busy && cmd_hit;
    end
endmodule

// File: rtl/hcf_regfile.sv
module hcf_regfile
    import hcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done_set,
    input  logic              cmd_reject,
    output logic              cmd_hit,
    output logic [31:0]       src_q,
    output logic [31:0]       dig_q,
    output logic [31:0]       key_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [3:0]        cmd_alg_bits,
    output logic              cmd_accum,
    output logic              cmd_be,
    output logic              done_flag,
    output logic              ovf_flag
);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(OFS_SRC);
    localparam logic [ADDR_W-1:0] A_DIG = ADDR_W'(OFS_DIGEST);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_LEN = ADDR_W'(OFS_LEN);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);

    logic [31:0] cmd_q;
    logic        cfg_we;
    logic        sts_hit;

    assign cfg_we  = bus_wr && !busy;
    assign cmd_hit = bus_wr && (bus_addr == A_CMD);
    assign sts_hit = bus_wr && (bus_addr == A_STS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dig_q <= '0;
            key_q <= '0;
            len_q <= '0;
            cmd_q <= '0;
        end else if (cfg_we) begin
            if (bus_addr == A_SRC) src_q <= bus_wdata;
            if (bus_addr == A_DIG) dig_q <= bus_wdata;
            if (bus_addr == A_KEY) key_q <= bus_wdata;
            if (bus_addr == A_LEN) len_q <= bus_wdata[LEN_W-1:0];
            if (bus_addr == A_CMD) cmd_q <= bus_wdata;
        end
    end

    // Completion and overflow flags: a set event wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (done_set)                                done_flag <= 1'b1;
            else if (sts_hit && bus_wdata[STS_DONE_BIT]) done_flag <= 1'b0;
            if (cmd_reject)                              ovf_flag  <= 1'b1;
            else if (sts_hit && bus_wdata[STS_OVF_BIT])  ovf_flag  <= 1'b0;
        end
    end

    assign cmd_alg_bits = {cmd_q[10], cmd_q[6], cmd_q[5], cmd_q[4]};
    assign cmd_accum    = cmd_q[CMD_ACC_BIT];
    assign cmd_be       = cmd_q[CMD_BE_BIT];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STS: begin
                bus_rdata[STS_BUSY_BIT] = busy;
                bus_rdata[STS_DONE_BIT] = done_flag;
                bus_rdata[STS_OVF_BIT]  = ovf_flag;
            end
            A_SRC:   bus_rdata = src_q;
            A_DIG:   bus_rdata = dig_q;
            A_KEY:   bus_rdata = key_q;
            A_LEN:   bus_rdata = 32'(len_q);
            A_CMD:   bus_rdata = cmd_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hash_csr_frontend.sv
module hash_csr_frontend
    import hcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              job_start,
    output logic [31:0]       job_src_addr,
    output logic [31:0]       job_digest_addr,
    output logic [31:0]       job_key_addr,
    output logic [LEN_W-1:0]  job_len,
    output logic [2:0]        job_algo,
    output logic              job_accum,
    output logic              job_big_endian,
    input  logic              job_done
);
    logic      busy, done_set, cmd_reject, cmd_hit;
    logic      done_flag, ovf_flag;
    logic [3:0] cmd_alg_bits;
    hcf_algo_e wr_algo, job_algo_e;
    logic      wr_algo_ok;

    // Decode the incoming command to decide acceptance
    hcf_algo_decode u_dec_wr (
        .alg_bits ({bus_wdata[10], bus_wdata[6], bus_wdata[5], bus_wdata[4]}),
        .algo     (wr_algo)
    );
    assign wr_algo_ok = (wr_algo != ALG_NONE);

    // Decode the stored command for the datapath
    hcf_algo_decode u_dec_job (
        .alg_bits (cmd_alg_bits),
        .algo     (job_algo_e)
    );
    assign job_algo = job_algo_e;

    hcf_job_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_hit    (cmd_hit),
        .algo_ok    (wr_algo_ok),
        .job_done   (job_done),
        .busy       (busy),
        .job_start  (job_start),
        .done_set   (done_set),
        .cmd_reject (cmd_reject)
    );

    hcf_regfile #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .busy         (busy),
        .done_set     (done_set),
        .cmd_reject   (cmd_reject),
        .cmd_hit      (cmd_hit),
        .src_q        (job_src_addr),
        .dig_q        (job_digest_addr),
        .key_q        (job_key_addr),
        .len_q        (job_len),
        .cmd_alg_bits (cmd_alg_bits),
        .cmd_accum    (job_accum),
        .cmd_be       (job_big_endian),
        .done_flag    (done_flag),
        .ovf_flag     (ovf_flag)
    );
endmodule

// File: rtl/hcf_checker.sv
module hcf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        job_start,
    input logic        job_done,
    input logic        cmd_hit,
    input logic        algo_ok,
    input logic        done_flag,
    input logic        ovf_flag,
    input logic [31:0] src,
    input logic [31:0] key
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start); // R3
    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_hit && algo_ok) |=> (busy && job_start)); // R3
    AST_BAD_ALGO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_hit && !algo_ok) |=> (!busy && !job_start)); // R5
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && job_done) |=> (!busy && done_flag)); // R6
    AST_REJECT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_hit) |=> (ovf_flag && !job_start)); // R8
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(src) && $stable(key))); // R9
endmodule

bind hash_csr_frontend hcf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .job_start (job_start),
    .job_done  (job_done),
    .cmd_hit   (cmd_hit),
    .algo_ok   (wr_algo_ok),
    .done_flag (done_flag),
    .ovf_flag  (ovf_flag),
    .src       (job_src_addr),
    .key       (job_key_addr)
);

// File: tb/tb_hash_csr_frontend.sv
`timescale 1ns/1ps
module tb_hash_csr_frontend;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              job_start;
    logic [31:0]       job_src_addr, job_digest_addr, job_key_addr;
    logic [LEN_W-1:0]  job_len;
    logic [2:0]        job_algo;
    logic              job_accum, job_big_endian;
    logic              job_done = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hash_csr_frontend #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .job_start(job_start),
        .job_src_addr(job_src_addr), .job_digest_addr(job_digest_addr),
        .job_key_addr(job_key_addr), .job_len(job_len), .job_algo(job_algo),
        .job_accum(job_accum), .job_big_endian(job_big_endian), .job_done(job_done)
    );

    localparam logic [7:0] A_STS = 8'h1C, A_SRC = 8'h20, A_DIG = 8'h24,
                           A_KEY = 8'h28, A_LEN = 8'h2C, A_CMD = 8'h30;
    localparam logic [31:0] BUSY = 32'h1, DONE = 32'h200, OVF = 32'h80_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STS, v); chk("R1 status", v, 32'h0);
        rd(A_SRC, v); chk("R1 src", v, 32'h0);
        rd(A_CMD, v); chk("R1 cmd", v, 32'h0);
        chk("R1 job_start", {31'b0, job_start}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_SRC, 32'h1000_0040);
        wr(A_DIG, 32'h2000_0080);
        wr(A_KEY, 32'h3000_00C0);
        wr(A_LEN, 32'hFF12_3456);
        rd(A_SRC, v); chk("R2 src", v, 32'h1000_0040);
        rd(A_DIG, v); chk("R2 digest", v, 32'h2000_0080);
        rd(A_KEY, v); chk("R2 key", v, 32'h3000_00C0);
        rd(A_LEN, v); chk("R2 len", v, 32'h0012_3456);
        chk("R2 len port", 32'(job_len), 32'h0012_3456);
        chk("R2 src port", job_src_addr, 32'h1000_0040);
    endtask

    task automatic t_launch_sha256();
        logic [31:0] v;
        wr(A_CMD, 32'h158);
        chk("R3 start after write", {31'b0, job_start}, 32'h1);
        chk("R4 algo sha256", {29'b0, job_algo}, 32'd2);
        chk("R4 accum", {31'b0, job_accum}, 32'h1);
        chk("R4 big endian", {31'b0, job_big_endian}, 32'h1);
        rd(A_STS, v);
        chk("R3 start one cycle", {31'b0, job_start}, 32'h0);
        chk("R3 busy", v, BUSY);
        done_pulse();
        rd(A_STS, v); chk("R6 done clears busy", v, DONE);
    endtask

    task automatic t_algos();
        logic [31:0] v;
        logic [31:0] codes [3] = '{32'h20, 32'h460, 32'h60};
        logic [2:0]  exps  [3] = '{3'd1, 3'd3, 3'd4};
        for (int i = 0; i < 3; i++) begin
            wr(A_STS, DONE);
            wr(A_CMD, codes[i]);
            chk("R3 start", {31'b0, job_start}, 32'h1);
            chk("R4 algo", {29'b0, job_algo}, {29'b0, exps[i]});
            chk("R4 flags off", {30'b0, job_accum, job_big_endian}, 32'h0);
            done_pulse();
            rd(A_STS, v); chk("R6 done", v, DONE);
        end
    endtask

    task automatic t_bad_algo();
        logic [31:0] v;
        wr(A_CMD, 32'h10);
        chk("R5 no start 0x10", {31'b0, job_start}, 32'h0);
        rd(A_STS, v); chk("R5 idle 0x10", v & BUSY, 32'h0);
        wr(A_CMD, 32'h70);
        chk("R5 no start 0x70", {31'b0, job_start}, 32'h0);
        rd(A_STS, v); chk("R5 idle 0x70", v & BUSY, 32'h0);
        chk("R4 none code", {29'b0, job_algo}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_STS, 32'h0);
        rd(A_STS, v); chk("R7 write 0 keeps", v, DONE);
        wr(A_STS, DONE);
        rd(A_STS, v); chk("R7 write 1 clears", v, 32'h0);
        wr(A_CMD, 32'h20);
        @(negedge clk);
        job_done = 1'b1; bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = DONE;
        @(negedge clk);
        job_done = 1'b0; bus_wr = 1'b0;
        rd(A_STS, v); chk("R7 set wins", v, DONE);
        wr(A_STS, DONE);
        done_pulse();
        rd(A_STS, v); chk("R6 done while idle", v, 32'h0);
    endtask

    task automatic t_busy_reject();
        logic [31:0] v;
        wr(A_CMD, 32'h20);
        wr(A_CMD, 32'h50);
        chk("R8 no restart", {31'b0, job_start}, 32'h0);
        rd(A_STS, v); chk("R8 ovf+busy", v, BUSY | OVF);
        chk("R8 algo kept", {29'b0, job_algo}, 32'd1);
        rd(A_CMD, v); chk("R8 cmd kept", v, 32'h20);
        wr(A_SRC, 32'hDEAD_BEEF);
        wr(A_LEN, 32'h0000_0001);
        rd(A_SRC, v); chk("R9 src frozen", v, 32'h1000_0040);
        rd(A_LEN, v); chk("R9 len frozen", v, 32'h0012_3456);
        done_pulse();
        rd(A_STS, v); chk("R8 ovf stays", v, DONE | OVF);
        wr(A_STS, OVF);
        rd(A_STS, v); chk("R8 ovf clear", v, DONE);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h21, 32'h1234_5678);
        rd(8'h34, v); chk("R10 read 0x34", v, 32'h0);
        rd(8'h00, v); chk("R10 read 0x00", v, 32'h0);
        rd(8'h18, v); chk("R10 read 0x18", v, 32'h0);
        rd(A_SRC, v); chk("R10 src intact", v, 32'h1000_0040);
        rd(A_STS, v); chk("R10 status intact", v, DONE);
        chk("R10 no start", {31'b0, job_start}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_launch_sha256();
        t_algos();
        t_bad_algo();
        t_w1c();
        t_busy_reject();
        t_unmapped();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule